// File: doc/BRIEF.md
# Runahead Mode Controller

This block sits beside the in-order retire point of a simple pipelined core and keeps it useful while the oldest micro-op waits on a last-level cache miss. It executes the decoded micro-op stream one entry per cycle against its own register file. When a load is presented together with a miss indication, the controller copies the register file into a checkpoint, records the load's program counter and switches to a speculative mode instead of stalling.

In speculative mode, micro-ops keep executing. Each register carries an invalid bit, and results that depend on the missing data are tagged invalid. Loads and stores whose address operand is valid issue a prefetch request. Nothing they compute lasts. When the miss-return signal arrives, the checkpoint is copied back and every invalid bit is cleared. The controller then raises a one-cycle flush and presents the saved load address as the restart point. A debug read port and a mode output let the surrounding logic and the bench inspect the state.

Top module: `rah_ctrl`

## Requirements
- R1: After reset, runahead_o, flush_o and pf_valid_o are 0. Every register reads 0 with its invalid bit clear.
- R2: In normal mode, the op codes behave as follows, and no prefetch is issued. Op 0 writes rd = rs1 + rs2. Op 1 writes rd = rs1 + imm. Op 2 is a load that, without a miss, writes rd = ld_data_i. Op 3 is a store that writes no register.
- R3: A valid op-2 micro-op with llc_miss_i high in normal mode sets runahead_o in the next cycle. From that cycle, restart_pc_o holds that micro-op's uop_pc_i.
- R4: The checkpoint taken on entry holds the register values from before the triggering load wrote its destination.
- R5: The destination of the triggering load becomes invalid. Ops 0 and 1 write an invalid result when any source they read is invalid. A valid result written to a register clears its invalid bit.
- R6: In runahead mode, an op-2 or op-3 micro-op whose rs1 is valid sets pf_valid_o in the next cycle, with pf_addr_o = rs1 + imm. No register write is made to memory.
- R7: In runahead mode, an op-2 or op-3 micro-op whose rs1 is invalid issues no prefetch. For op 2, rd is marked invalid.
- R8: A further op-2 miss while in runahead mode takes no new checkpoint and leaves restart_pc_o unchanged. It marks rd invalid and still issues its prefetch.
- R9: miss_ret_i high in runahead mode produces a one-cycle flush_o in the next cycle. In that same cycle runahead_o is 0, all registers equal the checkpoint with invalid bits clear, and any micro-op presented with miss_ret_i has no effect.
- R10: miss_ret_i high in normal mode has no effect on mode, flush or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uop_valid_i | input | 1 | Micro-op present this cycle |
| uop_op_i | input | 2 | Op code: 0 add, 1 add immediate, 2 load, 3 store |
| uop_rd_i | input | AW | Destination register |
| uop_rs1_i | input | AW | First source, also address base |
| uop_rs2_i | input | AW | Second source |
| uop_imm_i | input | XLEN | Immediate or address offset |
| uop_pc_i | input | PCW | Micro-op program counter |
| ld_data_i | input | XLEN | Load data for a hitting load |
| llc_miss_i | input | 1 | The presented load missed the last-level cache |
| miss_ret_i | input | 1 | Data for the checkpointed miss has returned |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | XLEN | Prefetch address |
| flush_o | output | 1 | One-cycle pipeline flush on exit |
| restart_pc_o | output | PCW | Restart address (triggering load) |
| runahead_o | output | 1 | 1 in runahead mode, 0 in normal mode |
| dbg_addr_i | input | AW | Register select for inspection |
| dbg_data_o | output | XLEN | Selected register value |
| dbg_inv_o | output | 1 | Selected register invalid bit |

## Verification
The assertions assume that the micro-op stream is in program order, so the presented micro-op is always the oldest. They also assume llc_miss_i is only meaningful alongside a valid load, and that miss_ret_i is the sole exit trigger. The stimulus honours this: it raises llc_miss_i only on loads and raises miss_ret_i both inside runahead mode and, as a negative case, in normal mode. Scenarios cover dependence chains through the missing register, invalid addresses, a nested miss, and a micro-op arriving in the exit cycle.

// File: rtl/rah_pkg.sv
package rah_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_ADDI  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STORE = 2'd3
  } rah_op_e;
endpackage

// File: rtl/rah_exec.sv
module rah_exec
  import rah_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  rah_op_e           op_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic              a_inv_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic              b_inv_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [XLEN-1:0]   ld_data_i,
  input  logic              miss_i,
  input  logic              spec_i,
  output logic              wr_en_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic              wr_inv_o,
  output logic              pf_req_o,
  output logic [XLEN-1:0]   pf_addr_o
);
  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = a_i + b_i;
    wr_inv_o  = a_inv_i | b_inv_i;
    pf_req_o  = 1'b0;
    pf_addr_o = a_i + imm_i;
    unique case (op_i)
      OP_ADD:  wr_en_o = 1'b1;
      OP_ADDI: begin
        wr_en_o   = 1'b1;
        wr_data_o = a_i + imm_i;
        wr_inv_o  = a_inv_i;
      end
      OP_LOAD: begin
        wr_en_o   = 1'b1;
        wr_data_o = ld_data_i;
        wr_inv_o  = a_inv_i | miss_i;
        pf_req_o  = spec_i & ~a_inv_i;
      end
      OP_STORE: pf_req_o = spec_i & ~a_inv_i; // never writes memory
      default: ;
    endcase
  end
endmodule

// File: rtl/rah_regfile.sv
module rah_regfile #(
  parameter int NREGS = 8,
  parameter int XLEN  = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            wr_inv_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  input  logic [AW-1:0]   rc_i,
  output logic [XLEN-1:0] a_o,
  output logic            a_inv_o,
  output logic [XLEN-1:0] b_o,
  output logic            b_inv_o,
  output logic [XLEN-1:0] c_o,
  output logic            c_inv_o,
  output logic            any_inv_o
);
  logic [XLEN-1:0]  val_arr [NREGS];
  logic [NREGS-1:0] inv_vec;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [XLEN-1:0] val_q, ckpt_q;
    logic            inv_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= '0;
        ckpt_q <= '0;
        inv_q  <= 1'b0;
      end else if (restore_i) begin
        val_q <= ckpt_q;
        inv_q <= 1'b0;
      end else begin
        if (save_i) ckpt_q <= val_q;
        if (wr_en_i && wr_addr_i == AW'(g)) begin
          val_q <= wr_data_i;
          inv_q <= wr_inv_i;
        end
      end
    end
    assign val_arr[g] = val_q;
    assign inv_vec[g] = inv_q;
  end

  assign a_o       = val_arr[ra_i];
  assign a_inv_o   = inv_vec[ra_i];
  assign b_o       = val_arr[rb_i];
  assign b_inv_o   = inv_vec[rb_i];
  assign c_o       = val_arr[rc_i];
  assign c_inv_o   = inv_vec[rc_i];
  assign any_inv_o = |inv_vec;

  AST_RESTORE_CLEARS_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (inv_vec == '0)); // R9
  AST_INV_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !restore_i) |=> (inv_vec[$past(wr_addr_i)] == $past(wr_inv_i))); // R5
endmodule

// File: rtl/rah_mode_fsm.sv
module rah_mode_fsm #(
  parameter int PCW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic           is_load_i,
  input  logic           miss_i,
  input  logic           ret_i,
  input  logic [PCW-1:0] pc_i,
  output logic           spec_o,
  output logic           save_o,
  output logic           restore_o,
  output logic           flush_o,
  output logic [PCW-1:0] restart_pc_o
);
  logic           spec_q, flush_q;
  logic [PCW-1:0] restart_pc_q;

  assign restore_o = spec_q & ret_i;
  assign save_o    = go_i & is_load_i & miss_i & ~spec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q       <= 1'b0;
      flush_q      <= 1'b0;
      restart_pc_q <= '0;
    end else begin
      flush_q <= restore_o;
      if (restore_o) spec_q <= 1'b0;
      else if (save_o) begin
        spec_q       <= 1'b1;
        restart_pc_q <= pc_i;
      end
    end
  end

  assign spec_o       = spec_q;
  assign flush_o      = flush_q;
  assign restart_pc_o = restart_pc_q;

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |=> !flush_q); // R9
  AST_FLUSH_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> (!spec_q && $past(spec_q))); // R9
  AST_ENTRY_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spec_q) |-> (restart_pc_q == $past(pc_i))); // R3
  AST_NO_RECHECKPOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_q && !ret_i) |=> $stable(restart_pc_q)); // R8
  AST_RET_IDLE_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spec_q && ret_i) |=> !flush_q); // R10
endmodule

// File: rtl/rah_ctrl.sv
module rah_ctrl
  import rah_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int XLEN  = 16,
  parameter int PCW   = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            uop_valid_i,
  input  logic [1:0]      uop_op_i,
  input  logic [AW-1:0]   uop_rd_i,
  input  logic [AW-1:0]   uop_rs1_i,
  input  logic [AW-1:0]   uop_rs2_i,
  input  logic [XLEN-1:0] uop_imm_i,
  input  logic [PCW-1:0]  uop_pc_i,
  input  logic [XLEN-1:0] ld_data_i,
  input  logic            llc_miss_i,
  input  logic            miss_ret_i,
  output logic            pf_valid_o,
  output logic [XLEN-1:0] pf_addr_o,
  output logic            flush_o,
  output logic [PCW-1:0]  restart_pc_o,
  output logic            runahead_o,
  input  logic [AW-1:0]   dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic            dbg_inv_o
);
  rah_op_e         op;
  logic            spec, save, restore, go;
  logic            wr_en, wr_inv, pf_req, any_inv;
  logic [XLEN-1:0] a, b, wr_data, pf_addr;
  logic            a_inv, b_inv;
  logic            pf_valid_q;
  logic [XLEN-1:0] pf_addr_q;

  assign op = rah_op_e'(uop_op_i);
  assign go = uop_valid_i & ~restore; // exit cycle drops the micro-op

  rah_mode_fsm #(.PCW(PCW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .is_load_i   (op == OP_LOAD),
    .miss_i      (llc_miss_i),
    .ret_i       (miss_ret_i),
    .pc_i        (uop_pc_i),
    .spec_o      (spec),
    .save_o      (save),
    .restore_o   (restore),
    .flush_o     (flush_o),
    .restart_pc_o(restart_pc_o)
  );

  rah_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .save_i   (save),
    .restore_i(restore),
    .wr_en_i  (wr_en & go),
    .wr_addr_i(uop_rd_i),
    .wr_data_i(wr_data),
    .wr_inv_i (wr_inv),
    .ra_i     (uop_rs1_i),
    .rb_i     (uop_rs2_i),
    .rc_i     (dbg_addr_i),
    .a_o      (a),
    .a_inv_o  (a_inv),
    .b_o      (b),
    .b_inv_o  (b_inv),
    .c_o      (dbg_data_o),
    .c_inv_o  (dbg_inv_o),
    .any_inv_o(any_inv)
  );

  rah_exec #(.XLEN(XLEN)) u_exec (
    .op_i     (op),
    .a_i      (a),
    .a_inv_i  (a_inv),
    .b_i      (b),
    .b_inv_i  (b_inv),
    .imm_i    (uop_imm_i),
    .ld_data_i(ld_data_i),
    .miss_i   (llc_miss_i),
    .spec_i   (spec),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data),
    .wr_inv_o (wr_inv),
    .pf_req_o (pf_req),
    .pf_addr_o(pf_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_q <= 1'b0;
      pf_addr_q  <= '0;
    end else begin
      pf_valid_q <= go & pf_req;
      if (go & pf_req) pf_addr_q <= pf_addr;
    end
  end

  assign pf_valid_o = pf_valid_q;
  assign pf_addr_o  = pf_addr_q;
  assign runahead_o = spec;

  AST_PF_ONLY_SPEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_q |-> $past(spec)); // R6
  AST_NORMAL_ALL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spec |-> !any_inv); // R5
  AST_ENTRY_MARKS_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spec) |-> any_inv); // R5
endmodule

// File: tb/rah_ctrl_bench.sv
module rah_ctrl_bench;
  localparam int NR = 8;
  localparam int XW = 16;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          v = 1'b0;
  logic [1:0]    op = '0;
  logic [2:0]    rd = '0, rs1 = '0, rs2 = '0, dbg_addr = '0;
  logic [XW-1:0] imm = '0, ldd = '0;
  logic [PW-1:0] pc = '0;
  logic          miss = 1'b0, ret = 1'b0;
  logic          pf_valid, flush, mode, dbg_inv;
  logic [XW-1:0] pf_addr, dbg_data;
  logic [PW-1:0] restart_pc;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [XW-1:0] m_reg [NR];
  logic [XW-1:0] m_ck  [NR];
  logic          m_inv [NR];
  logic          m_mode = 0, m_flush = 0, m_pfv = 0;
  logic [XW-1:0] m_pfa = '0;
  logic [PW-1:0] m_pc = '0;

  always #10 clk = ~clk;

  rah_ctrl u_rah_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .uop_valid_i(v), .uop_op_i(op),
    .uop_rd_i(rd), .uop_rs1_i(rs1), .uop_rs2_i(rs2), .uop_imm_i(imm),
    .uop_pc_i(pc), .ld_data_i(ldd), .llc_miss_i(miss), .miss_ret_i(ret),
    .pf_valid_o(pf_valid), .pf_addr_o(pf_addr), .flush_o(flush),
    .restart_pc_o(restart_pc), .runahead_o(mode), .dbg_addr_i(dbg_addr),
    .dbg_data_o(dbg_data), .dbg_inv_o(dbg_inv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 mode", 32'(mode), 32'(m_mode));
    chk("R9 flush", 32'(flush), 32'(m_flush));
    chk("R6 pf_valid", 32'(pf_valid), 32'(m_pfv));
    if (m_pfv) chk("R6 pf_addr", 32'(pf_addr), 32'(m_pfa));
    if (m_mode) chk("R3 restart_pc", 32'(restart_pc), 32'(m_pc));
    for (int i = 0; i < NR; i++) begin
      dbg_addr = 3'(i);
      #1;
      chk("R5 inv", 32'(dbg_inv), 32'(m_inv[i]));
      if (!m_inv[i]) chk("R2 reg", 32'(dbg_data), 32'(m_reg[i]));
    end
  endtask

  task automatic model_step();
    logic leave, go, enter, ai;
    logic [XW-1:0] a, b;
    leave = m_mode && ret;
    go = v && !leave;
    a = m_reg[rs1]; b = m_reg[rs2]; ai = m_inv[rs1];
    if (leave) begin
      for (int i = 0; i < NR; i++) begin m_reg[i] = m_ck[i]; m_inv[i] = 0; end
      m_mode = 0; m_flush = 1; m_pfv = 0;
    end else begin
      m_flush = 0;
      enter = go && op == 2 && miss && !m_mode;
      m_pfv = go && m_mode && op[1] && !ai;
      if (m_pfv) m_pfa = a + imm;
      if (enter) begin
        for (int i = 0; i < NR; i++) m_ck[i] = m_reg[i];
        m_pc = pc; m_mode = 1;
      end
      if (go) begin
        case (op)
          2'd0: begin m_reg[rd] = a + b; m_inv[rd] = ai | m_inv[rs2]; end
          2'd1: begin m_reg[rd] = a + imm; m_inv[rd] = ai; end
          2'd2: begin m_reg[rd] = ldd; m_inv[rd] = ai | miss; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic step(input logic iv, input logic [1:0] iop, input int ird, input int ir1,
                      input int ir2, input logic [XW-1:0] iimm, input logic [PW-1:0] ipc,
                      input logic [XW-1:0] ild, input logic imiss, input logic iret);
    v = iv; op = iop; rd = 3'(ird); rs1 = 3'(ir1); rs2 = 3'(ir2);
    imm = iimm; pc = ipc; ldd = ild; miss = imiss; ret = iret;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL timeout: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_reg[i] = '0; m_ck[i] = '0; m_inv[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all(); // R1 reset state
    // R2 normal-mode execution, no prefetch
    step(1, 1, 1, 0, 0, 16'd5,   16'h10, 0, 0, 0);
    step(1, 1, 2, 0, 0, 16'd100, 16'h14, 0, 0, 0);
    step(1, 0, 3, 1, 2, 0,       16'h18, 0, 0, 0);
    step(1, 2, 4, 2, 0, 16'd4,   16'h1c, 16'h1234, 0, 0);
    step(1, 3, 0, 2, 1, 16'd8,   16'h20, 0, 0, 0);
    // R10 return in normal mode ignored
    step(1, 1, 6, 1, 0, 16'd3,   16'h24, 0, 0, 1);
    // R3 R4 R5 entry on missing load
    step(1, 2, 5, 2, 0, 16'd4,   16'h40, 16'hdead, 1, 0);
    step(1, 0, 6, 5, 1, 0,       16'h44, 0, 0, 0); // R5 propagate
    step(1, 1, 6, 1, 0, 16'd1,   16'h48, 0, 0, 0); // R5 valid write clears
    step(1, 2, 7, 2, 0, 16'd8,   16'h4c, 16'h0777, 0, 0); // R6 load prefetch
    step(1, 3, 0, 1, 3, 16'd2,   16'h50, 0, 0, 0); // R6 store prefetch
    step(1, 2, 1, 5, 0, 16'd0,   16'h54, 16'h1, 0, 0); // R7 invalid address
    step(1, 3, 0, 5, 2, 16'd6,   16'h58, 0, 0, 0); // R7 store dropped
    step(1, 2, 2, 3, 0, 16'd0,   16'h80, 16'h2, 1, 0); // R8 nested miss
    step(1, 1, 4, 1, 0, 16'd9,   16'h84, 0, 0, 0);
    // R9 exit with a micro-op in the same cycle
    step(1, 1, 3, 0, 0, 16'd77,  16'h88, 0, 0, 1);
    idle();
    step(1, 1, 3, 3, 0, 16'd1,   16'h44, 0, 0, 0);
    // second episode: entry, chain, exit
    step(1, 2, 3, 1, 0, 16'd0,   16'h60, 0, 1, 0);
    step(1, 0, 0, 3, 3, 0,       16'h64, 0, 0, 0);
    step(1, 3, 0, 4, 0, 16'h10,  16'h68, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0,       0,      0, 0, 1);
    idle();
    step(1, 0, 7, 0, 1, 0,       16'h70, 0, 0, 0);
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule